// File: doc/BRIEF.md
# Self-Calibrating Serial Byte Receiver

This block receives asynchronous serial bytes (one low start bit, eight data bits least significant first, one high stop bit) without knowing the bit rate in advance. Each burst opens with a calibration byte whose bits alternate, either 0x55 or 0xAA. The block times that byte's line transitions from its falling start edge, checks that the transitions are evenly spaced, and derives the clock-cycle length of one bit. It then receives the following bytes at that rate, and times every frame again from that frame's own falling start edge.

A burst ends on either of two conditions. One is an accepted byte that equals a programmable terminator value. The other is a programmable number of accepted data bytes. In both cases the block drops its lock and waits for a fresh calibration byte, which may arrive at a different rate. A two-flop synchronizer conditions the raw line before any edge logic sees it.

Top module: `autobaud_rx`

## Requirements
- R1: A 0x55 calibration frame at a bit period of B cycles sets `locked` high and makes `divisor` equal to B. The span from the start edge to the falling edge that begins data bit 7 lasts eight bit times, and it is divided by eight with truncation.
- R2: A 0xAA calibration frame at a bit period of B cycles sets `locked` high and makes `divisor` equal to B. Here the span runs from the start edge to the rising edge that begins data bit 7.
- R3: The calibration byte never appears on `rx_data`/`rx_valid`.
- R4: If any calibration interval differs from the reference interval by more than the reference shifted right by TOL_SHIFT, calibration is abandoned and `locked` stays low.
- R5: While locked, each frame is timed from its falling start edge. Bits are sampled at half the divisor past that edge and then once per divisor, with data taken LSB first. Each accepted byte is shown on `rx_data` with `rx_valid` high for exactly one cycle.
- R6: A low pulse on the line that has ended before the start-bit midpoint is rejected. It produces neither `rx_valid` nor `frame_err`, and the next frame is received normally.
- R7: A frame whose stop bit samples low pulses `frame_err` for one cycle and produces no `rx_valid`. The byte is not counted toward the burst length, and `locked` stays high.
- R8: An accepted byte equal to `stop_char` is delivered, and `locked` falls on the next cycle.
- R9: When `burst_len` is nonzero, `locked` falls on the cycle after the `burst_len`-th accepted data byte. A value of zero disables the count limit.
- R10: `divisor` does not change while locked. It keeps its last value after the burst ends, and a later calibration at a new rate replaces it.
- R11: After reset, `locked`, `rx_valid` and `frame_err` are low and `divisor` is zero.
- R12: `rx_valid` and `frame_err` are asserted only while `locked` is high, and never in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| stop_char | input | 8 | Byte value that terminates a burst |
| burst_len | input | CNT_W | Accepted data bytes per burst; 0 means unlimited |
| rx_data | output | 8 | Last accepted data byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| locked | output | 1 | Calibrated and receiving data |
| divisor | output | DIV_W | Measured bit period in clock cycles |
| frame_err | output | 1 | One-cycle pulse on a low stop bit |

## Verification
The hardest case to reach from the ports is a rejected calibration. The bench must produce a byte whose transition spacing is wrong. After the rejection, the stray transitions left in that byte must not leave the calibrator stuck or falsely locked. The stimulus sends a 0x55 with one bit stretched to twice its length, leaves the line idle long enough for the partial re-measurement to time out, and then checks that a clean calibration byte still locks. Glitch rejection and a low stop bit are each driven inside a locked burst. Around them, the scoreboard confirms that neither event costs a later byte or adds a spurious one.

// File: rtl/abr_pkg.sv
package abr_pkg;
  localparam int BYTE_W     = 8;
  localparam int SPAN_SHIFT = 3;   // calibration span covers eight bit times
  localparam logic [3:0] EDGES_ALT_HI = 4'd8;  // 0x55: edges up to start of bit 7
  localparam logic [3:0] EDGES_ALT_LO = 4'd7;  // 0xAA: edges up to start of bit 7

  typedef enum logic [1:0] {F_IDLE, F_START, F_DATA, F_STOP} frame_st_t;
  typedef enum logic {M_IDLE, M_RUN} meas_st_t;
endpackage

// File: rtl/abr_sync.sv
module abr_sync (
  input  logic clk,
  input  logic rst,
  input  logic line_async,
  output logic line_q,
  output logic fall_p,
  output logic edge_p
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= line_async;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign line_q = s2;
  assign fall_p = s3 & ~s2;
  assign edge_p = s3 ^ s2;
endmodule

// File: rtl/abr_measure.sv
module abr_measure #(
  parameter int DIV_W     = 16,
  parameter int TOL_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             fall_p,
  input  logic             edge_p,
  output logic             done,
  output logic [DIV_W-1:0] div_out
);
  import abr_pkg::*;
  localparam int TW = DIV_W + SPAN_SHIFT;
  localparam int XW = TW + 2;

  meas_st_t          st;
  logic [TW-1:0]     timer, last_t, first_iv, ref_iv;
  logic [3:0]        k, target;
  logic [TW-1:0]     iv;
  logic [XW-1:0]     limit;
  logic              late;

  function automatic logic close_to(input logic [XW-1:0] a, input logic [XW-1:0] b);
    logic [XW-1:0] d;
    d = (a > b) ? a - b : b - a;
    return d <= (b >> TOL_SHIFT);
  endfunction

  always_comb begin
    iv    = timer - last_t;
    limit = {1'b0, ref_iv, 1'b0} + ({2'b00, ref_iv} >> TOL_SHIFT);
    late  = (k != 4'd0) && ({2'b00, iv} > limit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= M_IDLE;
      timer    <= '0;
      last_t   <= '0;
      first_iv <= '0;
      ref_iv   <= '0;
      k        <= '0;
      target   <= EDGES_ALT_HI;
      done     <= 1'b0;
      div_out  <= '0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        st <= M_IDLE;
      end else begin
        case (st)
          M_IDLE: if (fall_p) begin
            timer  <= TW'(1);
            last_t <= '0;
            k      <= '0;
            st     <= M_RUN;
          end
          M_RUN: begin
            timer <= timer + TW'(1);
            if (edge_p) begin
              k      <= k + 4'd1;
              last_t <= timer;
              if (k == 4'd0) begin
                first_iv <= iv;
                ref_iv   <= iv;
              end else if (k == 4'd1) begin
                ref_iv <= iv;
                if (close_to({2'b00, first_iv}, {2'b00, iv}))
                  target <= EDGES_ALT_HI;
                else if (close_to({2'b00, first_iv}, {1'b0, iv, 1'b0}))
                  target <= EDGES_ALT_LO;
                else
                  st <= M_IDLE;
              end else if (!close_to({2'b00, iv}, {2'b00, ref_iv})) begin
                st <= M_IDLE;
              end else if (k + 4'd1 == target) begin
                done    <= 1'b1;
                div_out <= timer[TW-1:SPAN_SHIFT];
                st      <= M_IDLE;
              end
            end else if (late || (&timer)) begin
              st <= M_IDLE;
            end
          end
          default: st <= M_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/abr_frame.sv
module abr_frame #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             din,
  input  logic             fall_p,
  input  logic [DIV_W-1:0] div_in,
  output logic [7:0]       data_out,
  output logic             valid,
  output logic             ferr
);
  import abr_pkg::*;

  frame_st_t        st;
  logic [DIV_W-1:0] cnt;
  logic [2:0]       idx;
  logic [7:0]       shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= F_IDLE;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      data_out <= '0;
      valid    <= 1'b0;
      ferr     <= 1'b0;
    end else begin
      valid <= 1'b0;
      ferr  <= 1'b0;
      if (!en) begin
        st <= F_IDLE;
      end else begin
        case (st)
          F_IDLE: if (fall_p) begin
            cnt <= (div_in >> 1) - DIV_W'(1);
            st  <= F_START;
          end
          F_START: if (cnt == '0) begin
            if (!din) begin
              cnt <= div_in - DIV_W'(1);
              idx <= '0;
              st  <= F_DATA;
            end else begin
              st <= F_IDLE;
            end
          end else cnt <= cnt - DIV_W'(1);
          F_DATA: if (cnt == '0) begin
            shreg <= {din, shreg[7:1]};
            cnt   <= div_in - DIV_W'(1);
            if (idx == 3'd7) st <= F_STOP;
            else idx <= idx + 3'd1;
          end else cnt <= cnt - DIV_W'(1);
          F_STOP: if (cnt == '0) begin
            if (din) begin
              data_out <= shreg;
              valid    <= 1'b1;
            end else begin
              ferr <= 1'b1;
            end
            st <= F_IDLE;
          end else cnt <= cnt - DIV_W'(1);
          default: st <= F_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/autobaud_rx.sv
module autobaud_rx #(
  parameter int DIV_W     = 16,
  parameter int CNT_W     = 8,
  parameter int TOL_SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxd,
  input  logic [7:0]       stop_char,
  input  logic [CNT_W-1:0] burst_len,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             locked,
  output logic [DIV_W-1:0] divisor,
  output logic             frame_err
);
  logic             line_q, fall_p, edge_p;
  logic             meas_done;
  logic [DIV_W-1:0] meas_div;
  logic [CNT_W-1:0] byte_cnt;

  abr_sync u_sync (
    .clk(clk), .rst(rst), .line_async(rxd),
    .line_q(line_q), .fall_p(fall_p), .edge_p(edge_p)
  );

  abr_measure #(.DIV_W(DIV_W), .TOL_SHIFT(TOL_SHIFT)) u_meas (
    .clk(clk), .rst(rst), .en(!locked), .fall_p(fall_p), .edge_p(edge_p),
    .done(meas_done), .div_out(meas_div)
  );

  abr_frame #(.DIV_W(DIV_W)) u_frame (
    .clk(clk), .rst(rst), .en(locked), .din(line_q), .fall_p(fall_p),
    .div_in(divisor), .data_out(rx_data), .valid(rx_valid), .ferr(frame_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      locked   <= 1'b0;
      divisor  <= '0;
      byte_cnt <= '0;
    end else if (!locked && meas_done) begin
      locked   <= 1'b1;
      divisor  <= meas_div;
      byte_cnt <= '0;
    end else if (locked && rx_valid) begin
      byte_cnt <= byte_cnt + CNT_W'(1);
      if ((rx_data == stop_char) ||
          ((burst_len != '0) && (byte_cnt + CNT_W'(1) == burst_len)))
        locked <= 1'b0;
    end
  end
endmodule

// File: rtl/abr_checker.sv
module abr_checker #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid,
  input logic             frame_err,
  input logic             locked,
  input logic [DIV_W-1:0] divisor
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid); // R5
  AST_VALID_WHILE_LOCKED: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> locked); // R12
  AST_NO_VALID_WITH_ERR: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && frame_err)); // R12
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err); // R7
  AST_ERR_KEEPS_LOCK: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> locked); // R7
  AST_UNLOCK_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> $past(rx_valid)); // R8
  AST_DIV_HELD: assert property (@(posedge clk) disable iff (rst)
    (locked && $past(locked)) |-> $stable(divisor)); // R10
endmodule

bind autobaud_rx abr_checker #(.DIV_W(DIV_W)) u_abr_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .frame_err(frame_err),
  .locked(locked), .divisor(divisor)
);

// File: tb/autobaud_rx_test.sv
module autobaud_rx_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rxd = 1'b1;
  logic [7:0]  stop_char = 8'hE7;
  logic [7:0]  burst_len = 8'd0;
  logic [7:0]  rx_data;
  logic        rx_valid, locked, frame_err;
  logic [15:0] divisor;

  int total = 0;
  int bad = 0;
  int ferr_cnt = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  autobaud_rx uut (
    .clk(clk), .rst(rst), .rxd(rxd), .stop_char(stop_char), .burst_len(burst_len),
    .rx_data(rx_data), .rx_valid(rx_valid), .locked(locked),
    .divisor(divisor), .frame_err(frame_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic hold(input logic lvl, input int cycles);
    rxd = lvl;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, input int bt,
                           input bit good_stop, input bit is_data);
    if (is_data && good_stop) exp_q.push_back(b);
    @(negedge clk);
    hold(1'b0, bt);
    for (int i = 0; i < 8; i++) hold(b[i], bt);
    hold(good_stop, bt);
    hold(1'b1, 2 * bt);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin
        chk(locked, "R12", "valid while unlocked", int'(locked), 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "unexpected byte", int'(rx_data), -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(rx_data == e, "R5", "received byte", int'(rx_data), int'(e));
        end
      end
      if (frame_err) ferr_cnt++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(locked == 0, "R11", "locked after reset", int'(locked), 0);
    chk(rx_valid == 0, "R11", "valid after reset", int'(rx_valid), 0);
    chk(frame_err == 0, "R11", "frame_err after reset", int'(frame_err), 0);
    chk(divisor == 0, "R11", "divisor after reset", int'(divisor), 0);

    // R4: 0x55 with bit 3 stretched to two bit times
    @(negedge clk);
    hold(1'b0, 16); hold(1'b1, 16); hold(1'b0, 16); hold(1'b1, 16);
    hold(1'b0, 32); hold(1'b1, 16); hold(1'b0, 16); hold(1'b1, 16);
    hold(1'b0, 16); hold(1'b1, 160);
    chk(locked == 0, "R4", "locked after uneven calibration", int'(locked), 0);

    // R1: 0x55 at 16 cycles per bit
    send_byte(8'h55, 16, 1'b1, 1'b0);
    chk(locked == 1, "R1", "locked after 0x55", int'(locked), 1);
    chk(divisor == 16, "R1", "divisor after 0x55", int'(divisor), 16);
    chk(exp_q.size() == 0 && ferr_cnt == 0, "R3", "no output from calibration",
        exp_q.size(), 0);

    // R5: normal data
    send_byte(8'h12, 16, 1'b1, 1'b1);
    send_byte(8'hA5, 16, 1'b1, 1'b1);
    chk(exp_q.size() == 0, "R5", "bytes outstanding", exp_q.size(), 0);
    chk(locked == 1, "R5", "still locked", int'(locked), 1);

    // R6: short glitch then a real byte
    @(negedge clk);
    hold(1'b0, 4);
    hold(1'b1, 32);
    send_byte(8'h3C, 16, 1'b1, 1'b1);
    chk(ferr_cnt == 0, "R6", "frame errors after glitch", ferr_cnt, 0);
    chk(exp_q.size() == 0, "R6", "byte after glitch", exp_q.size(), 0);

    // R7: low stop bit
    send_byte(8'h81, 16, 1'b0, 1'b1);
    chk(ferr_cnt == 1, "R7", "frame error pulses", ferr_cnt, 1);
    chk(locked == 1, "R7", "lock kept after framing error", int'(locked), 1);
    send_byte(8'h66, 16, 1'b1, 1'b1);
    chk(exp_q.size() == 0, "R7", "byte after framing error", exp_q.size(), 0);

    // R8: terminator byte
    send_byte(8'hE7, 16, 1'b1, 1'b1);
    chk(exp_q.size() == 0, "R8", "terminator delivered", exp_q.size(), 0);
    chk(locked == 0, "R8", "unlocked after terminator", int'(locked), 0);

    // R2 + R9: 0xAA at 24 cycles per bit, count of three
    burst_len = 8'd3;
    send_byte(8'hAA, 24, 1'b1, 1'b0);
    chk(locked == 1, "R2", "locked after 0xAA", int'(locked), 1);
    chk(divisor == 24, "R2", "divisor after 0xAA", int'(divisor), 24);
    send_byte(8'h01, 24, 1'b1, 1'b1);
    send_byte(8'h80, 24, 1'b1, 1'b1);
    chk(locked == 1, "R9", "locked before count reached", int'(locked), 1);
    send_byte(8'h5A, 24, 1'b1, 1'b1);
    chk(locked == 0, "R9", "unlocked at count", int'(locked), 0);
    chk(exp_q.size() == 0, "R9", "burst bytes delivered", exp_q.size(), 0);

    // R10: recalibrate at a new rate, divisor held after the burst
    burst_len = 8'd1;
    send_byte(8'h55, 20, 1'b1, 1'b0);
    chk(divisor == 20, "R10", "divisor after recalibration", int'(divisor), 20);
    send_byte(8'hF0, 20, 1'b1, 1'b1);
    chk(locked == 0, "R10", "unlocked after single byte", int'(locked), 0);
    chk(divisor == 20, "R10", "divisor held after burst", int'(divisor), 20);
    chk(exp_q.size() == 0, "R10", "byte at new rate", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule